// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Controller

This block is the digital control core of a synchronous buck half-bridge driver. A single PWM input selects which of two power switches should conduct. The block turns that choice into a high-side gate enable and a low-side gate enable, and the two enables are never asserted together. When PWM rises, the low-side enable is removed first. The high-side enable follows after a programmed number of clock cycles. When PWM falls, the high-side enable is removed first. The low-side enable then waits until a comparator reports that the switch node has fallen, or until a fixed timeout expires.

Several conditions force both enables off: an active-low shutdown, a supply-good flag that is false, and an over-temperature flag. A separate active-low input holds only the low side off. The PWM input and the switch-node comparator each pass through a two-flop synchronizer. Leaving any forced-off condition restarts the normal guarded sequence. The dead time and the timeout are parameters counted in clock cycles.

Top module: `gate_sequencer`

## Requirements
- R1: PWM high leads to the high-side enable alone being asserted. PWM low leads to the low-side enable alone being asserted (with the low side not disabled).
- R2: While `shdn_n` is 0, both enables are 0 from the next clock edge onward, whatever PWM is doing.
- R3: While `ls_dis_n` is 0, `ls_en` is 0 from the next clock edge onward and `hs_en` still follows PWM. Once `ls_dis_n` returns to 1 with PWM low, `ls_en` rises at the next edge.
- R4: After `hs_en` falls, `ls_en` rises one edge after the synchronized `sw_low` reads 1, or else exactly `SW_TIMEOUT` edges after `hs_en` fell, whichever comes first.
- R5: After `ls_en` falls because PWM rose, `hs_en` rises exactly `DEAD_CYC`+1 edges later.
- R6: While `pgood` is 0, both enables are 0 from the next clock edge onward.
- R7: While `overtemp` is 1, both enables are 0 from the next clock edge onward. Normal operation resumes only after the flag clears.
- R8: `hs_en` and `ls_en` are never 1 in the same cycle. Neither enable rises in a cycle that directly follows a cycle in which the other enable was 1.
- R9: If PWM rises again while the low-side turn-on is still pending, that turn-on is cancelled. `ls_en` stays 0 and `hs_en` rises through the dead-time wait.
- R10: When a forced-off condition ends, both enables stay 0 for at least one edge. With PWM high, `hs_en` rises `DEAD_CYC`+2 edges after release. With PWM low, the adaptive low-side sequence is applied.
- R11: A PWM change made between clock edges takes effect on the enables at the third rising edge after it.
- R12: During reset both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm | input | 1 | Duty command, 1 = upper switch, 0 = lower switch |
| shdn_n | input | 1 | Active-low shutdown of both enables |
| ls_dis_n | input | 1 | Active-low hold-off of the low-side enable |
| pgood | input | 1 | Supply good, 0 = undervoltage lockout |
| overtemp | input | 1 | Over-temperature flag, 1 = force off |
| sw_low | input | 1 | Comparator: switch node below threshold |
| hs_en | output | 1 | High-side gate enable (registered) |
| ls_en | output | 1 | Low-side gate enable (registered) |

## Verification
The bound checker tests properties on every cycle. It checks that the two enables never overlap and that neither enable rises straight after the other was high. It also checks that shutdown, undervoltage, over-temperature and low-side disable each clear the enables they govern one edge later. Only the directed scenarios can show exact cycle counts. These include the three-edge synchronizer latency, the `DEAD_CYC`+1 dead time, the comparator path against the timeout path of the low-side turn-on, and the cancellation of a pending low-side turn-on. The scenarios also show the guarded restart that follows each forced-off condition.

// File: rtl/gsq_pkg.sv
package gsq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_LS_ON,
        ST_WAIT_DEAD_HS,
        ST_HS_ON,
        ST_WAIT_SW_LS
    } gsq_state_e;

    function automatic int gsq_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gsq_sync.sv
module gsq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gsq_fsm.sv
module gsq_fsm
    import gsq_pkg::*;
#(
    parameter int DEAD_CYC   = 3,
    parameter int SW_TIMEOUT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_off,
    input  logic ls_allow,
    input  logic pwm_s,
    input  logic sw_low_s,
    output logic hs_en,
    output logic ls_en
);

    localparam int CW = $clog2(gsq_max(DEAD_CYC, SW_TIMEOUT) + 1) + 1;
    localparam logic [CW-1:0] DEAD_LIM = CW'(DEAD_CYC);
    localparam logic [CW-1:0] TO_LIM   = CW'(SW_TIMEOUT - 1);

    typedef struct packed {
        gsq_state_e    st;
        logic [CW-1:0] cnt;
        logic          hs;
        logic          ls;
    } fsm_t;

    fsm_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.st = r_q.st;
        if (force_off) begin
            r_d.st  = ST_OFF;
            r_d.cnt = '0;
        end else begin
            case (r_q.st)
                ST_OFF: begin
                    r_d.cnt = '0;
                    r_d.st  = pwm_s ? ST_WAIT_DEAD_HS : ST_WAIT_SW_LS;
                end
                ST_LS_ON: begin
                    if (pwm_s) begin
                        r_d.st  = ST_WAIT_DEAD_HS;
                        r_d.cnt = '0;
                    end
                end
                ST_WAIT_DEAD_HS: begin
                    if (!pwm_s) begin
                        r_d.st  = ST_WAIT_SW_LS;
                        r_d.cnt = '0;
                    end else if (r_q.cnt == DEAD_LIM) begin
                        r_d.st  = ST_HS_ON;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_HS_ON: begin
                    if (!pwm_s) begin
                        r_d.st  = ST_WAIT_SW_LS;
                        r_d.cnt = '0;
                    end
                end
                ST_WAIT_SW_LS: begin
                    if (pwm_s) begin
                        r_d.st  = ST_WAIT_DEAD_HS;
                        r_d.cnt = '0;
                    end else if (sw_low_s || r_q.cnt == TO_LIM) begin
                        r_d.st  = ST_LS_ON;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: begin
                    r_d.st  = ST_OFF;
                    r_d.cnt = '0;
                end
            endcase
        end
        r_d.hs = (r_d.st == ST_HS_ON);
        r_d.ls = (r_d.st == ST_LS_ON) && ls_allow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_OFF;
            r_q.cnt <= '0;
            r_q.hs  <= 1'b0;
            r_q.ls  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hs_en = r_q.hs;
    assign ls_en = r_q.ls;

endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer #(
    parameter int DEAD_CYC   = 3,
    parameter int SW_TIMEOUT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm,
    input  logic shdn_n,
    input  logic ls_dis_n,
    input  logic pgood,
    input  logic overtemp,
    input  logic sw_low,
    output logic hs_en,
    output logic ls_en
);

    localparam int NSYNC = 2;

    logic [NSYNC-1:0] raw_w, syn_w;
    logic             force_off;

    assign raw_w     = {sw_low, pwm};
    assign force_off = !shdn_n || !pgood || overtemp;

    gsq_sync #(.WIDTH(NSYNC), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_w),
        .sync_out (syn_w)
    );

    gsq_fsm #(.DEAD_CYC(DEAD_CYC), .SW_TIMEOUT(SW_TIMEOUT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_off (force_off),
        .ls_allow  (ls_dis_n),
        .pwm_s     (syn_w[0]),
        .sw_low_s  (syn_w[1]),
        .hs_en     (hs_en),
        .ls_en     (ls_en)
    );

endmodule

// File: rtl/gate_sequencer_chk.sv
module gate_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic shdn_n,
    input logic ls_dis_n,
    input logic pgood,
    input logic overtemp,
    input logic hs_en,
    input logic ls_en
);

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    assert_hs_rise_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> !$past(ls_en));

    assert_ls_rise_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> !$past(hs_en));

    assert_shutdown_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> (!hs_en && !ls_en));

    assert_ls_disable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_dis_n |=> !ls_en);

    assert_uvlo_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pgood |=> (!hs_en && !ls_en));

    assert_overtemp_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overtemp |=> (!hs_en && !ls_en));

    assert_release_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shdn_n && pgood && !overtemp) |=> (!hs_en && !ls_en));

endmodule

bind gate_sequencer gate_sequencer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shdn_n   (shdn_n),
    .ls_dis_n (ls_dis_n),
    .pgood    (pgood),
    .overtemp (overtemp),
    .hs_en    (hs_en),
    .ls_en    (ls_en)
);

// File: tb/tb_gate_sequencer.sv
`timescale 1ns/1ps
module tb_gate_sequencer;

    localparam int DEAD = 3;
    localparam int SWTO = 20;

    logic clk = 1'b0;
    logic rst_n, pwm, shdn_n, ls_dis_n, pgood, overtemp, sw_low;
    logic hs_en, ls_en;

    int n_chk = 0;
    int n_fail = 0;
    int overlap_seen = 0;
    int ls_high_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gate_sequencer #(.DEAD_CYC(DEAD), .SW_TIMEOUT(SWTO)) dut (
        .clk(clk), .rst_n(rst_n), .pwm(pwm), .shdn_n(shdn_n),
        .ls_dis_n(ls_dis_n), .pgood(pgood), .overtemp(overtemp),
        .sw_low(sw_low), .hs_en(hs_en), .ls_en(ls_en)
    );

    always @(negedge clk) begin
        if (hs_en && ls_en) overlap_seen++;
        if (ls_en) ls_high_seen++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts rising edges until the chosen enable shows lvl (sampled at negedge)
    task automatic meas(input bit sel_ls, input logic lvl, input int maxc, output int n);
        n = -1;
        for (int i = 0; i < maxc; i++) begin
            @(posedge clk); @(negedge clk);
            if ((sel_ls ? ls_en : hs_en) == lvl) begin
                n = i + 1;
                return;
            end
        end
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 0; pwm = 0; shdn_n = 1; ls_dis_n = 1; pgood = 1;
        overtemp = 0; sw_low = 0;
        idle(4);
        chk(!hs_en && !ls_en, "R12 reset", {hs_en, ls_en}, 0);
    endtask

    task automatic t_startup;
        int n;
        rst_n = 1;
        meas(1, 1, 100, n);
        chk(n == SWTO + 1, "R10 R4 startup low side via timeout", n, SWTO + 1);
        chk(!hs_en, "R1 pwm low keeps high side off", hs_en, 0);
    endtask

    task automatic t_rise;
        int n;
        pwm = 1;
        meas(1, 0, 20, n);
        chk(n == 3, "R11 low side off on third edge", n, 3);
        meas(0, 1, 20, n);
        chk(n == DEAD + 1, "R5 dead time before high side", n, DEAD + 1);
        chk(hs_en && !ls_en, "R1 pwm high gives high side", {hs_en, ls_en}, 2);
    endtask

    task automatic t_fall_timeout;
        int n;
        sw_low = 0;
        pwm = 0;
        meas(0, 0, 20, n);
        chk(n == 3, "R11 high side off on third edge", n, 3);
        meas(1, 1, 100, n);
        chk(n == SWTO, "R4 timeout path", n, SWTO);
    endtask

    task automatic t_fall_comparator;
        int n;
        sw_low = 1;
        pwm = 0;
        meas(0, 0, 20, n);
        chk(n == 3, "R1 high side drops", n, 3);
        meas(1, 1, 100, n);
        chk(n == 1, "R4 comparator path", n, 1);
        sw_low = 0;
    endtask

    task automatic t_cancel;
        int n;
        sw_low = 0;
        pwm = 0;
        meas(0, 0, 20, n);
        idle(5);
        ls_high_seen = 0;
        pwm = 1;
        meas(0, 1, 40, n);
        chk(n == DEAD + 4, "R9 cancel goes to dead wait", n, DEAD + 4);
        chk(ls_high_seen == 0, "R9 low side never turned on", ls_high_seen, 0);
    endtask

    task automatic t_ls_disable;
        int n;
        ls_dis_n = 0;
        ls_high_seen = 0;
        pwm = 0;
        meas(0, 0, 20, n);
        chk(n == 3, "R3 high side still follows pwm", n, 3);
        idle(SWTO + 10);
        chk(ls_high_seen == 0, "R3 low side held off", ls_high_seen, 0);
        ls_dis_n = 1;
        meas(1, 1, 10, n);
        chk(n == 1, "R3 low side resumes", n, 1);
        pwm = 1;
        meas(0, 1, 40, n);
    endtask

    task automatic t_force(input int which, input string req);
        int n;
        pwm = 1;
        idle(2);
        if (which == 0) shdn_n = 0;
        else if (which == 1) pgood = 0;
        else overtemp = 1;
        meas(0, 0, 10, n);
        chk(n == 1, req, n, 1);
        idle(6);
        chk(!hs_en && !ls_en, req, {hs_en, ls_en}, 0);
        ls_high_seen = 0;
        shdn_n = 1; pgood = 1; overtemp = 0;
        meas(0, 1, 40, n);
        chk(n == DEAD + 2, "R10 guarded restart with pwm high", n, DEAD + 2);
        chk(ls_high_seen == 0, "R10 low side stays off", ls_high_seen, 0);
    endtask

    task automatic t_ot_low;
        int n;
        sw_low = 1;
        pwm = 0;
        meas(1, 1, 20, n);
        overtemp = 1;
        meas(1, 0, 10, n);
        chk(n == 1, "R7 overtemp clears low side", n, 1);
        idle(4);
        overtemp = 0;
        meas(1, 1, 20, n);
        chk(n == 2, "R10 R7 adaptive restart with pwm low", n, 2);
        sw_low = 0;
    endtask

    initial begin
        t_reset;
        t_startup;
        t_rise;
        t_fall_timeout;
        t_rise;
        t_fall_comparator;
        t_rise;
        t_cancel;
        t_ls_disable;
        t_force(0, "R2 shutdown forces off");
        t_force(1, "R6 undervoltage forces off");
        t_force(2, "R7 overtemp forces off");
        t_ot_low;
        chk(overlap_seen == 0, "R8 no overlap", overlap_seen, 0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule